// File: doc/BRIEF.md
# Genetic Training Loop Sequencer

This block is the control core of a hardware genetic trainer for a single neuron. It owns the population schedule. For each generation it asks an external neuron datapath to evaluate six candidate weight sets, one after another. It scores every returned output against a target value and ranks the six candidates. It then decides whether to stop or to ask an external regeneration engine to breed a new population. The neuron arithmetic and the bit-level crossover and mutation are outside this block. The block only tells those units which candidate to decode and which four candidates act as parents.

The score of a candidate is the absolute distance between the neuron output and the target. Training stops when the best score is within a tolerance. If that never happens, training stops after a fixed number of generations and raises a timeout flag. While it is stopped, the block keeps presenting the winning candidate index, so the neuron datapath keeps the winning weights applied. Phase flags show evaluation, analysis and completion, and an output shows the current generation number.

Top module: `ga_train_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, every request output and every status flag is low, and the generation count is 0.
- R2: A start pulse launches evaluation of chromosome indices 0,1,2,3,4,5 in that order. Each index gets a one-cycle eval_req_o, issued in the cycle after the previous result is taken, and forming_o stays high from the first request until the sixth result.
- R3: The fitness of a chromosome is |neuron_out_i − target_i|, and best_err_o reports the fitness of the best-ranked chromosome.
- R4: analysing_o is high for exactly the one cycle after the sixth result is taken, and at most one of forming_o, analysing_o, finished_o is high in any cycle.
- R5: The ranking is stable: a lower fitness ranks first and equal fitness keeps the lower index first. parents_o carries the four best indices, 3 bits each, with rank 0 in bits [2:0] and rank 3 in bits [11:9].
- R6: If the best fitness is <= TOL, the block enters the finished state with finished_o high, timeout_o low, and best_idx_o equal to the rank-0 index.
- R7: Otherwise, when the generation is not the last allowed one, the block pulses regen_req_o for one cycle with parents_o valid and iter_o already incremented by 1. It then waits for regen_done_i and restarts evaluation at index 0.
- R8: If generation MAX_ITER−1 fails the tolerance test, the block finishes with finished_o and timeout_o both high, iter_o equal to MAX_ITER−1, and best_idx_o equal to the best index of that generation.
- R9: While finished, chrom_idx_o equals best_idx_o, and all outputs hold their values; neuron_valid_i and regen_done_i are ignored until the next start pulse.
- R10: A start pulse that arrives while training is in progress is ignored, and the sequence of requests and results is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle or finished |
| target_i | input | VAL_W | Target output, held stable during a run |
| eval_req_o | output | 1 | One-cycle request to evaluate chrom_idx_o |
| chrom_idx_o | output | IDX_W | Chromosome being evaluated, or the winner once finished |
| neuron_valid_i | input | 1 | Neuron result valid strobe |
| neuron_out_i | input | VAL_W | Neuron output for the requested chromosome |
| regen_req_o | output | 1 | One-cycle request to breed a new generation |
| parents_o | output | NPAR*IDX_W | Ranked parent indices, rank 0 in the low field |
| regen_done_i | input | 1 | Regeneration engine completion strobe |
| forming_o | output | 1 | Evaluation phase active |
| analysing_o | output | 1 | Ranking and decision phase active |
| finished_o | output | 1 | Training stopped |
| timeout_o | output | 1 | Stopped because the generation limit was reached |
| iter_o | output | ITER_W | Current generation number |
| best_idx_o | output | IDX_W | Index of the best chromosome of the last analysed generation |
| best_err_o | output | VAL_W | Fitness of that chromosome |

## Verification
A request eval_req_o appears in the cycle after the start edge, and again in the cycle after each result edge. analysing_o follows the sixth result by one cycle. regen_req_o or finished_o follows analysis by one further cycle. The bench drives inputs on falling edges and reads outputs on falling edges, so each result is sampled half a cycle after the rising edge that produced it. The neuron model answers each request two cycles later and the regeneration model one cycle later. A scoreboard queue holds, for each generation, the expected parents, winner, fitness and stop kind. These values are computed from the stimulus tables by an insertion sort. The queue is compared against each regen_req_o pulse and each rising edge of finished_o.

// File: rtl/ga_seq_pkg.sv
package ga_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL_REQ,
    ST_EVAL_WAIT,
    ST_ANALYSE,
    ST_REGEN_REQ,
    ST_REGEN_WAIT,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/ga_err_calc.sv
module ga_err_calc #(
  parameter int VAL_W = 7
) (
  input  logic [VAL_W-1:0] a_i,
  input  logic [VAL_W-1:0] b_i,
  output logic [VAL_W-1:0] diff_o
);
  always_comb begin
    if (a_i >= b_i) diff_o = a_i - b_i;
    else            diff_o = b_i - a_i;
  end
endmodule

// File: rtl/ga_err_bank.sv
module ga_err_bank #(
  parameter int POP   = 6,
  parameter int ERR_W = 7,
  parameter int IDX_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [ERR_W-1:0]     wr_data_i,
  output logic [POP*ERR_W-1:0] errs_o
);
  for (genvar g = 0; g < POP; g++) begin : g_entry
    logic [ERR_W-1:0] err_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       err_q <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))       err_q <= wr_data_i;
    end
    assign errs_o[g*ERR_W +: ERR_W] = err_q;
  end
endmodule

// File: rtl/ga_rank_sort.sv
module ga_rank_sort #(
  parameter int POP   = 6,
  parameter int NPAR  = 4,
  parameter int ERR_W = 7,
  parameter int IDX_W = 3
) (
  input  logic [POP*ERR_W-1:0]  errs_i,
  output logic [NPAR*IDX_W-1:0] order_o,
  output logic [ERR_W-1:0]      best_err_o
);
  logic [POP*IDX_W-1:0] rank_flat;

  // rank = number of entries that must precede this one (stable on ties)
  for (genvar i = 0; i < POP; i++) begin : g_rank
    int unsigned cnt;
    always_comb begin
      cnt = 0;
      for (int j = 0; j < POP; j++) begin
        if (j != i) begin
          if ((errs_i[j*ERR_W +: ERR_W] < errs_i[i*ERR_W +: ERR_W]) ||
              ((errs_i[j*ERR_W +: ERR_W] == errs_i[i*ERR_W +: ERR_W]) && (j < i)))
            cnt = cnt + 1;
        end
      end
    end
    assign rank_flat[i*IDX_W +: IDX_W] = IDX_W'(cnt);
  end

  always_comb begin
    order_o = '0;
    for (int r = 0; r < NPAR; r++) begin
      for (int i = 0; i < POP; i++) begin
        if (rank_flat[i*IDX_W +: IDX_W] == IDX_W'(r))
          order_o[r*IDX_W +: IDX_W] = IDX_W'(i);
      end
    end
  end

  assign best_err_o = errs_i[order_o[IDX_W-1:0]*ERR_W +: ERR_W];
endmodule

// File: rtl/ga_train_seq.sv
module ga_train_seq
  import ga_seq_pkg::*;
#(
  parameter int POP      = 6,
  parameter int NPAR     = 4,
  parameter int VAL_W    = 7,
  parameter int TOL      = 2,
  parameter int MAX_ITER = 16,
  localparam int IDX_W   = (POP > 1) ? $clog2(POP) : 1,
  localparam int ITER_W  = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [VAL_W-1:0]      target_i,
  output logic                  eval_req_o,
  output logic [IDX_W-1:0]      chrom_idx_o,
  input  logic                  neuron_valid_i,
  input  logic [VAL_W-1:0]      neuron_out_i,
  output logic                  regen_req_o,
  output logic [NPAR*IDX_W-1:0] parents_o,
  input  logic                  regen_done_i,
  output logic                  forming_o,
  output logic                  analysing_o,
  output logic                  finished_o,
  output logic                  timeout_o,
  output logic [ITER_W-1:0]     iter_o,
  output logic [IDX_W-1:0]      best_idx_o,
  output logic [VAL_W-1:0]      best_err_o
);
  seq_state_e            state_q;
  logic [IDX_W-1:0]      idx_q;
  logic [ITER_W-1:0]     iter_q;
  logic                  timeout_q;
  logic [IDX_W-1:0]      best_idx_q;
  logic [VAL_W-1:0]      best_err_q;
  logic [NPAR*IDX_W-1:0] parents_q;

  logic [VAL_W-1:0]      cur_err;
  logic [POP*VAL_W-1:0]  errs;
  logic [NPAR*IDX_W-1:0] order;
  logic [VAL_W-1:0]      rank_best_err;
  logic                  take_result;

  assign take_result = (state_q == ST_EVAL_WAIT) && neuron_valid_i;

  ga_err_calc #(.VAL_W(VAL_W)) u_err (
    .a_i    (neuron_out_i),
    .b_i    (target_i),
    .diff_o (cur_err)
  );

  ga_err_bank #(.POP(POP), .ERR_W(VAL_W), .IDX_W(IDX_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (take_result),
    .wr_idx_i  (idx_q),
    .wr_data_i (cur_err),
    .errs_o    (errs)
  );

  ga_rank_sort #(.POP(POP), .NPAR(NPAR), .ERR_W(VAL_W), .IDX_W(IDX_W)) u_rank (
    .errs_i     (errs),
    .order_o    (order),
    .best_err_o (rank_best_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      iter_q     <= '0;
      timeout_q  <= 1'b0;
      best_idx_q <= '0;
      best_err_q <= '0;
      parents_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q   <= ST_EVAL_REQ;
            idx_q     <= '0;
            iter_q    <= '0;
            timeout_q <= 1'b0;
          end
        end
        ST_EVAL_REQ: state_q <= ST_EVAL_WAIT;
        ST_EVAL_WAIT: begin
          if (neuron_valid_i) begin
            if (idx_q == IDX_W'(POP - 1)) begin
              state_q <= ST_ANALYSE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_EVAL_REQ;
            end
          end
        end
        ST_ANALYSE: begin
          parents_q  <= order;
          best_idx_q <= order[IDX_W-1:0];
          best_err_q <= rank_best_err;
          if (rank_best_err <= VAL_W'(TOL)) begin
            state_q <= ST_DONE;
          end else if (iter_q == ITER_W'(MAX_ITER - 1)) begin
            state_q   <= ST_DONE;
            timeout_q <= 1'b1;
          end else begin
            iter_q  <= iter_q + 1'b1;
            state_q <= ST_REGEN_REQ;
          end
        end
        ST_REGEN_REQ: state_q <= ST_REGEN_WAIT;
        ST_REGEN_WAIT: begin
          if (regen_done_i) begin
            idx_q   <= '0;
            state_q <= ST_EVAL_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign eval_req_o  = (state_q == ST_EVAL_REQ);
  assign regen_req_o = (state_q == ST_REGEN_REQ);
  assign forming_o   = (state_q == ST_EVAL_REQ) || (state_q == ST_EVAL_WAIT);
  assign analysing_o = (state_q == ST_ANALYSE);
  assign finished_o  = (state_q == ST_DONE);
  assign timeout_o   = timeout_q;
  assign chrom_idx_o = (state_q == ST_DONE) ? best_idx_q : idx_q;
  assign parents_o   = parents_q;
  assign iter_o      = iter_q;
  assign best_idx_o  = best_idx_q;
  assign best_err_o  = best_err_q;
endmodule

// File: rtl/ga_train_seq_chk.sv
module ga_train_seq_chk #(
  parameter int POP    = 6,
  parameter int VAL_W  = 7,
  parameter int TOL    = 2,
  parameter int IDX_W  = 3,
  parameter int ITER_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              eval_req_o,
  input logic              regen_req_o,
  input logic              forming_o,
  input logic              analysing_o,
  input logic              finished_o,
  input logic              timeout_o,
  input logic [ITER_W-1:0] iter_o,
  input logic [IDX_W-1:0]  chrom_idx_o,
  input logic [IDX_W-1:0]  best_idx_o,
  input logic [VAL_W-1:0]  best_err_o
);
  assert_phase_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({forming_o, analysing_o, finished_o}));

  assert_req_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_req_o |=> (!eval_req_o && forming_o));

  assert_idx_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chrom_idx_o < IDX_W'(POP));

  assert_analyse_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    analysing_o |=> (regen_req_o || finished_o));

  assert_iter_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(regen_req_o) |-> (iter_o == ITER_W'($past(iter_o) + 1'b1)));

  assert_stop_tol_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finished_o && !timeout_o) |-> (best_err_o <= VAL_W'(TOL)));

  assert_timeout_fin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> finished_o);

  assert_done_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finished_o && !start_i) |=>
      (finished_o && $stable(best_idx_o) && $stable(iter_o) && (chrom_idx_o == best_idx_o)));
endmodule

bind ga_train_seq ga_train_seq_chk #(
  .POP(POP), .VAL_W(VAL_W), .TOL(TOL), .IDX_W(IDX_W), .ITER_W(ITER_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .eval_req_o  (eval_req_o),
  .regen_req_o (regen_req_o),
  .forming_o   (forming_o),
  .analysing_o (analysing_o),
  .finished_o  (finished_o),
  .timeout_o   (timeout_o),
  .iter_o      (iter_o),
  .chrom_idx_o (chrom_idx_o),
  .best_idx_o  (best_idx_o),
  .best_err_o  (best_err_o)
);

// File: tb/ga_train_seq_tb_top.sv
module ga_train_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int POP = 6, NPAR = 4, VAL_W = 7, TOL = 2, MAX_ITER = 4;
  localparam int IDX_W = 3, ITER_W = 2;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [VAL_W-1:0] target_i = '0, neuron_out_i = '0;
  logic neuron_valid_i = 1'b0, regen_done_i = 1'b0;
  logic eval_req_o, regen_req_o, forming_o, analysing_o, finished_o, timeout_o;
  logic [IDX_W-1:0] chrom_idx_o, best_idx_o;
  logic [NPAR*IDX_W-1:0] parents_o;
  logic [ITER_W-1:0] iter_o;
  logic [VAL_W-1:0] best_err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ga_train_seq #(.POP(POP), .NPAR(NPAR), .VAL_W(VAL_W), .TOL(TOL), .MAX_ITER(MAX_ITER)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .target_i(target_i),
    .eval_req_o(eval_req_o), .chrom_idx_o(chrom_idx_o),
    .neuron_valid_i(neuron_valid_i), .neuron_out_i(neuron_out_i),
    .regen_req_o(regen_req_o), .parents_o(parents_o), .regen_done_i(regen_done_i),
    .forming_o(forming_o), .analysing_o(analysing_o), .finished_o(finished_o),
    .timeout_o(timeout_o), .iter_o(iter_o), .best_idx_o(best_idx_o), .best_err_o(best_err_o)
  );

  typedef struct packed {
    logic                  fin;
    logic                  tmo;
    logic [ITER_W-1:0]     iter;
    logic [IDX_W-1:0]      best;
    logic [VAL_W-1:0]      berr;
    logic [NPAR*IDX_W-1:0] par;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0, n_fail = 0;
  logic [VAL_W-1:0] vals [MAX_ITER][POP];
  int exp_idx = 0;
  bit inject = 1'b0;
  bit finished_run = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setv(input int g, input int a0, a1, a2, a3, a4, a5);
    vals[g][0] = VAL_W'(a0); vals[g][1] = VAL_W'(a1); vals[g][2] = VAL_W'(a2);
    vals[g][3] = VAL_W'(a3); vals[g][4] = VAL_W'(a4); vals[g][5] = VAL_W'(a5);
  endtask

  // driver side of the scoreboard: expected events from the stimulus tables
  task automatic push_expected(input int target);
    for (int g = 0; g < MAX_ITER; g++) begin
      int e[POP];
      int ord[POP];
      exp_t it;
      for (int i = 0; i < POP; i++) begin
        e[i] = int'(vals[g][i]) - target;
        if (e[i] < 0) e[i] = -e[i];
        ord[i] = i;
      end
      for (int i = 1; i < POP; i++) begin
        int k = ord[i];
        int j = i - 1;
        while (j >= 0 && e[ord[j]] > e[k]) begin
          ord[j+1] = ord[j];
          j--;
        end
        ord[j+1] = k;
      end
      it = '0;
      it.iter = ITER_W'(g);
      it.best = IDX_W'(ord[0]);
      it.berr = VAL_W'(e[ord[0]]);
      for (int r = 0; r < NPAR; r++) it.par[r*IDX_W +: IDX_W] = IDX_W'(ord[r]);
      if (e[ord[0]] <= TOL) begin
        it.fin = 1'b1; exp_q.push_back(it); break;
      end else if (g == MAX_ITER - 1) begin
        it.fin = 1'b1; it.tmo = 1'b1; exp_q.push_back(it); break;
      end else begin
        it.iter = ITER_W'(g + 1);
        exp_q.push_back(it);
      end
    end
  endtask

  // neuron and regeneration models
  initial begin
    int ncnt = -1, rcnt = -1, last_idx = -1;
    logic [VAL_W-1:0] pend = '0;
    forever begin
      @(negedge clk);
      neuron_valid_i = 1'b0;
      regen_done_i   = 1'b0;
      if (last_idx == POP - 1) begin
        check(analysing_o && !forming_o, "R4", "analysing after sixth result", int'(analysing_o), 1);
      end
      last_idx = -1;
      if (ncnt == 0) begin
        neuron_out_i   = pend;
        neuron_valid_i = 1'b1;
        last_idx       = int'(chrom_idx_o);
        ncnt = -1;
      end else if (ncnt > 0) ncnt--;
      if (rcnt == 0) begin
        regen_done_i = 1'b1;
        rcnt = -1;
      end else if (rcnt > 0) rcnt--;
      if (eval_req_o) begin
        check(int'(chrom_idx_o) == exp_idx, "R2", "chromosome order", int'(chrom_idx_o), exp_idx);
        check(forming_o, "R2", "forming during request", int'(forming_o), 1);
        pend    = vals[iter_o][chrom_idx_o];
        exp_idx = (exp_idx + 1) % POP;
        ncnt    = 1;
      end
      if (regen_req_o) rcnt = 0;
      if (inject) begin
        neuron_out_i   = '0;
        neuron_valid_i = 1'b1;
        regen_done_i   = 1'b1;
        inject = 1'b0;
      end
    end
  end

  // monitor side of the scoreboard
  initial begin
    logic prev_fin = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (regen_req_o) begin
        if (exp_q.size() == 0) check(1'b0, "R7", "unexpected regen request", 1, 0);
        else begin
          e = exp_q.pop_front();
          check(!e.fin, "R7", "regen instead of stop", 1, 0);
          check(parents_o == e.par, "R5", "parent order", int'(parents_o), int'(e.par));
          check(iter_o == e.iter, "R7", "generation count at regen", int'(iter_o), int'(e.iter));
          check(best_err_o == e.berr, "R3", "best fitness", int'(best_err_o), int'(e.berr));
        end
      end
      if (finished_o && !prev_fin) begin
        if (exp_q.size() == 0) check(1'b0, "R6", "unexpected finish", 1, 0);
        else begin
          e = exp_q.pop_front();
          check(e.fin, "R6", "finished early", 0, 1);
          check(best_idx_o == e.best, "R6", "winner index", int'(best_idx_o), int'(e.best));
          check(best_err_o == e.berr, "R3", "winner fitness", int'(best_err_o), int'(e.berr));
          check(timeout_o == e.tmo, "R8", "timeout flag", int'(timeout_o), int'(e.tmo));
          check(iter_o == e.iter, "R8", "final generation", int'(iter_o), int'(e.iter));
          check(chrom_idx_o == e.best, "R9", "winner presented", int'(chrom_idx_o), int'(e.best));
        end
      end
      prev_fin = finished_o;
    end
  end

  task automatic run(input int target, input bit restart_mid);
    logic [IDX_W-1:0] b;
    logic [ITER_W-1:0] itv;
    push_expected(target);
    exp_idx  = 0;
    target_i = VAL_W'(target);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (restart_mid) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1;               // R10: ignored while busy
      @(negedge clk); start_i = 1'b0;
    end
    for (int c = 0; c < 2000 && !finished_o; c++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(finished_o, "R9", "still finished", int'(finished_o), 1);
    check(chrom_idx_o == best_idx_o, "R9", "index held on winner", int'(chrom_idx_o), int'(best_idx_o));
    b = best_idx_o; itv = iter_o;
    inject = 1'b1;
    repeat (4) @(negedge clk);
    check(finished_o && best_idx_o == b && iter_o == itv && !eval_req_o,
          "R9", "stray strobes ignored", int'(best_idx_o), int'(b));
    check(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    if (!finished_run) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!eval_req_o && !regen_req_o && !forming_o && !analysing_o && !finished_o && !timeout_o,
          "R1", "flags in reset", 1, 0);
    check(iter_o == '0, "R1", "generation in reset", int'(iter_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(!eval_req_o && !forming_o && !finished_o, "R1", "idle after reset", 1, 0);

    // converge in generation 0
    setv(0, 60, 40, 52, 49, 70, 10);
    run(50, 1'b0);
    // ties in generation 0, exact hit in generation 1
    setv(0, 40, 20, 35, 25, 40, 0);
    setv(1, 33, 33, 90, 29, 30, 60);
    run(30, 1'b0);
    // TOL+1 everywhere then TOL exactly at the last index
    setv(0, 97, 97, 97, 97, 97, 97);
    setv(1, 90, 50, 96, 60, 95, 98);
    run(100, 1'b0);
    // never converges: timeout, with a start pulse while busy
    setv(0, 10, 9, 8, 7, 6, 5);
    setv(1, 3, 50, 3, 60, 4, 3);
    setv(2, 100, 90, 80, 70, 60, 50);
    setv(3, 20, 20, 20, 20, 20, 20);
    run(0, 1'b1);

    finished_run = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule